// File: doc/BRIEF.md
# Command/Data Parallel Bus Slave

This block places a peripheral on a microcontroller's external memory bus as two byte-wide locations. A single address bit does not pick a register. It marks each access as either a command phase or a data phase. Writes become single-cycle strobes in the core clock domain, each carrying its byte. Reads of the data location raise a one-cycle request to the core, and the byte the core presents is driven back while the read is in progress.

The bus side can be wired two ways. In the first, the address line comes from a spare port pin and the latch-enable input is tied low; the block then ignores any address phase on the data lines. In the second, the address and data share the bus. Here the block takes bit 0 of the bus as the phase select when the latch enable falls, and from then on that value replaces the address pin. Every bus strobe passes through a two-flop synchroniser before the block looks for its edges. The bidirectional data bus is split into input, output and output-enable for the pad ring. The interrupt line is passed straight through.

Top module: `cmdbus_slave`

## Requirements
- R1: A write with the phase select at 1 (command) gives exactly one `cmd_we` pulse, and `cmd_byte` holds the byte that was on the bus.
- R2: A write with the phase select at 0 (data) gives exactly one `dat_we` pulse, and `dat_byte` holds the byte that was on the bus.
- R3: The write strobe is one clock wide and comes only after the write strobe rises. No strobe appears while the write strobe is still low, and a write never produces both strobes.
- R4: A write or read made while chip select is high produces no strobe and no read request.
- R5: A read with the phase select at 0, while chip select and the read strobe are both low, drives `rd_byte` with `d_oe` = 1. It also gives exactly one `rd_req` pulse per read.
- R6: A read with the phase select at 1 drives 0x00 and gives no `rd_req`.
- R7: `d_oe` is 0 whenever chip select or the read strobe is high.
- R8: Until the latch enable has been seen high, the `a0` pin alone chooses the phase, whatever bit 0 of the bus holds.
- R9: After the latch enable has gone high, bit 0 of the bus, taken when the latch enable falls, chooses the phase in place of the `a0` pin.
- R10: `irq_n_out` always equals `irq_n_in`.
- R11: After reset, `d_oe`, `cmd_we`, `dat_we` and `rd_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| d_in | input | 8 | Bus data from the pad |
| d_out | output | 8 | Bus data to the pad |
| d_oe | output | 1 | Pad output enable |
| a0 | input | 1 | Phase select pin (1 = command, 0 = data) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch enable, active high |
| irq_n_in | input | 1 | Interrupt from the core |
| irq_n_out | output | 1 | Interrupt to the bus |
| cmd_we | output | 1 | Command-write strobe |
| cmd_byte | output | 8 | Command byte |
| dat_we | output | 1 | Data-write strobe |
| dat_byte | output | 8 | Data byte |
| rd_req | output | 1 | Data-read request |
| rd_byte | input | 8 | Byte returned by the core |

## Verification
The bench holds the write strobe low for several clocks and checks that no strobe has appeared yet. A design that acted on the falling edge, or that fired on every clock while the strobe was low, would fail this check. It also drives bus bit 0 opposite to the `a0` pin in the non-multiplexed mode, so a design that snooped the address phase would steer bytes to the wrong location. Once the latch enable has pulsed, it drives the `a0` pin opposite to the latched bit to show that the latched value wins. It also issues strobes with chip select high, where a design that ignored chip select would emit spurious strobes or drive the bus.

// File: rtl/cmdbus_slave.sv
module cmdbus_slave #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  input  logic          a0,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ale,
  input  logic          irq_n_in,
  output logic          irq_n_out,
  output logic          cmd_we,
  output logic [DW-1:0] cmd_byte,
  output logic          dat_we,
  output logic [DW-1:0] dat_byte,
  output logic          rd_req,
  input  logic [DW-1:0] rd_byte
);

  logic [1:0] cs_s, wr_s, rd_s, ale_s, a0_s;
  logic [DW-1:0] d_s1, d_s2, hold_d;
  logic wr_q, rd_q, hold_a0, adr_lat, mux_mode;

  wire sel      = !cs_s[1];
  wire wr_rise  = wr_s[1] && !wr_q;
  wire rd_fall  = !rd_s[1] && rd_q;
  wire wr_phase = mux_mode ? adr_lat : hold_a0;
  wire rd_phase = mux_mode ? adr_lat : a0_s[1];
  wire pin_phase = mux_mode ? adr_lat : a0;

  assign irq_n_out = irq_n_in;
  assign d_oe      = !cs_n && !rd_n;
  assign d_out     = pin_phase ? '0 : rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s     <= 2'b11;
      wr_s     <= 2'b11;
      rd_s     <= 2'b11;
      ale_s    <= 2'b00;
      a0_s     <= 2'b00;
      d_s1     <= '0;
      d_s2     <= '0;
      wr_q     <= 1'b1;
      rd_q     <= 1'b1;
      hold_d   <= '0;
      hold_a0  <= 1'b0;
      adr_lat  <= 1'b0;
      mux_mode <= 1'b0;
      cmd_we   <= 1'b0;
      dat_we   <= 1'b0;
      rd_req   <= 1'b0;
      cmd_byte <= '0;
      dat_byte <= '0;
    end else begin
      cs_s  <= {cs_s[0], cs_n};
      wr_s  <= {wr_s[0], wr_n};
      rd_s  <= {rd_s[0], rd_n};
      ale_s <= {ale_s[0], ale};
      a0_s  <= {a0_s[0], a0};
      d_s1  <= d_in;
      d_s2  <= d_s1;
      wr_q  <= wr_s[1];
      rd_q  <= rd_s[1];
      if (!wr_s[1]) begin
        hold_d  <= d_s2;
        hold_a0 <= a0_s[1];
      end
      if (ale_s[1]) begin
        adr_lat  <= d_s2[0];
        mux_mode <= 1'b1;
      end
      cmd_we <= wr_rise && sel && wr_phase;
      dat_we <= wr_rise && sel && !wr_phase;
      rd_req <= rd_fall && sel && !rd_phase;
      if (wr_rise && sel && wr_phase)  cmd_byte <= hold_d;
      if (wr_rise && sel && !wr_phase) dat_byte <= hold_d;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && dat_we)); // R3
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> !cmd_we); // R3
  AST_DAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |=> !dat_we); // R3
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R5
  AST_SELECTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we || dat_we) |-> !$past(cs_n, 3)); // R4
  AST_IRQ_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_out == irq_n_in); // R10

endmodule

// File: tb/cmdbus_slave_tb_top.sv
module cmdbus_slave_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] d_in = 0, rd_byte = 8'hA5;
  logic a0 = 0, cs_n = 1, rd_n = 1, wr_n = 1, ale = 0, irq_n_in = 1;
  logic [7:0] d_out, cmd_byte, dat_byte;
  logic d_oe, irq_n_out, cmd_we, dat_we, rd_req;
  int n_chk = 0, n_fail = 0, n_cmd = 0, n_dat = 0, n_rdq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmdbus_slave dut_i (.clk, .rst_n, .d_in, .d_out, .d_oe, .a0, .cs_n, .rd_n,
    .wr_n, .ale, .irq_n_in, .irq_n_out, .cmd_we, .cmd_byte, .dat_we,
    .dat_byte, .rd_req, .rd_byte);

  always @(posedge clk) begin
    if (cmd_we) n_cmd++;
    if (dat_we) n_dat++;
    if (rd_req) n_rdq++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input bit pin, input logic [7:0] val, input bit sel,
                          input bit exp_cmd, input string tag);
    int c0 = n_cmd, d0 = n_dat;
    @(negedge clk);
    a0 = pin; d_in = val; cs_n = !sel;
    cyc(2); wr_n = 0; cyc(5);
    chk(n_cmd == c0 && n_dat == d0, {tag, " R3 no strobe while low"}, n_cmd + n_dat, c0 + d0);
    wr_n = 1; cyc(6); cs_n = 1; cyc(3);
    if (!sel) begin
      chk(n_cmd == c0 && n_dat == d0, {tag, " R4 unselected"}, n_cmd + n_dat, c0 + d0);
    end else if (exp_cmd) begin
      chk(n_cmd == c0 + 1 && n_dat == d0, {tag, " R1 cmd count"}, n_cmd - c0, 1);
      chk(cmd_byte == val, {tag, " R1 cmd byte"}, cmd_byte, val);
    end else begin
      chk(n_dat == d0 + 1 && n_cmd == c0, {tag, " R2 dat count"}, n_dat - d0, 1);
      chk(dat_byte == val, {tag, " R2 dat byte"}, dat_byte, val);
    end
  endtask

  task automatic do_read(input bit pin, input bit sel, input logic [7:0] exp,
                         input bit exp_req, input string tag);
    int r0 = n_rdq;
    @(negedge clk);
    a0 = pin; cs_n = !sel; cyc(2); rd_n = 0; cyc(6); #1;
    if (sel) begin
      chk(d_oe == 1, {tag, " R5 oe during read"}, d_oe, 1);
      chk(d_out == exp, {tag, " R5/R6 read value"}, d_out, exp);
    end else
      chk(d_oe == 0, {tag, " R7 oe unselected"}, d_oe, 0);
    @(negedge clk); rd_n = 1; #1;
    chk(d_oe == 0, {tag, " R7 oe after read"}, d_oe, 0);
    cyc(4); cs_n = 1; cyc(3);
    chk(n_rdq == r0 + (exp_req ? 1 : 0), {tag, " R5/R6/R4 rd_req count"}, n_rdq - r0, exp_req);
  endtask

  task automatic t_reset;
    cyc(3); rst_n = 1; cyc(4); #1;
    chk(!d_oe && !cmd_we && !dat_we && !rd_req, "R11 reset state",
        {d_oe, cmd_we, dat_we, rd_req}, 0);
  endtask

  task automatic t_irq;
    irq_n_in = 0; #1; chk(irq_n_out == 0, "R10 irq low", irq_n_out, 0);
    irq_n_in = 1; #1; chk(irq_n_out == 1, "R10 irq high", irq_n_out, 1);
  endtask

  task automatic t_idle_bus;
    @(negedge clk); rd_n = 0; #1;
    chk(d_oe == 0, "R7 rd low cs high", d_oe, 0);
    rd_n = 1; cs_n = 0; #1;
    chk(d_oe == 0, "R7 cs low rd high", d_oe, 0);
    cs_n = 1;
  endtask

  task automatic t_plain_mode;
    do_write(1, 8'h3C, 1, 1, "cmd wr");
    do_write(0, 8'hC3, 1, 0, "dat wr");
    do_write(1, 8'h00, 1, 1, "R8 cmd even bus");
    do_write(0, 8'hFF, 1, 0, "R8 dat odd bus");
    do_write(1, 8'h77, 0, 1, "R4 cmd unsel");
    do_read(0, 1, 8'hA5, 1, "dat rd");
    rd_byte = 8'h5A;
    do_read(0, 1, 8'h5A, 1, "dat rd2");
    do_read(1, 1, 8'h00, 0, "R6 cmd rd");
    do_read(0, 0, 8'h00, 0, "R4 rd unsel");
  endtask

  task automatic ale_cycle(input logic [7:0] adr);
    @(negedge clk); d_in = adr; ale = 1; cyc(4); ale = 0; cyc(4);
  endtask

  task automatic t_mux_mode;
    ale_cycle(8'h01);
    do_write(0, 8'h91, 1, 1, "R9 latched cmd");
    do_read(0, 1, 8'h00, 0, "R9 latched cmd rd");
    ale_cycle(8'hFE);
    do_write(1, 8'h19, 1, 0, "R9 latched dat");
    do_read(1, 1, 8'h5A, 1, "R9 latched dat rd");
  endtask

  initial begin
    t_reset();
    t_irq();
    t_idle_bus();
    t_plain_mode();
    t_mux_mode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule